// File: doc/BRIEF.md
# Partial Bitstream Loader with In-Flight CRC

This block moves one partial-configuration image from a word-wide source FIFO into a parallel configuration port that cannot buffer and cannot stall. The host gives a word count, the CRC the image should produce and the identifier of the module it contains, then pulses start. The loader waits until the FIFO holds the whole image. It raises a decouple signal so the static logic ignores the region being rewritten. It then pushes every word on consecutive clocks while it runs a CRC over the same words.

After the last word the computed CRC is compared with the expected one. On a match the block reports done, publishes the module identifier as the loaded one and releases decouple. On a mismatch, or if the port signals busy while words are flowing, it enters a sticky error state. In that state decouple stays high and the loaded identifier reads zero until software clears the error. The data width of the port and FIFO is a parameter (8, 16 or 32 bits, default 32).

Top module: `pbit_loader`

## Requirements
- R1: After reset the port enable is high (inactive), the read/write select is high, fifo_pop, decouple, done and error are low, and loaded_id is zero.
- R2: The read/write select is low (write) from the cycle after a start is accepted until the block is back in idle, so it is low whenever the enable is low.
- R3: Start is accepted only in idle and only with a non-zero word_count. A start with count zero, or any start while a load or an error is pending, changes nothing.
- R4: No word reaches the port until fifo_level is at least the accepted word count. Then exactly that many words are presented on consecutive cycles, enable low. Each word is the FIFO head, and it is popped in the same cycle.
- R5: Decouple rises exactly one cycle before the first word and stays high through every streaming cycle and the check cycle.
- R6: The CRC is CRC-32 with polynomial 0x04C11DB7, initial value 0xFFFFFFFF, bits fed most significant first, with no reflection and no final inversion. It runs over the words in the order they are presented.
- R7: On a CRC match, done goes high and loaded_id takes the identifier latched at start, in the cycle after the check. Decouple is low in that same cycle. Done stays high until the next accepted start.
- R8: On a CRC mismatch, error goes high and stays high, decouple stays high and loaded_id reads zero, until err_clear is sampled high. The block then returns to idle with error and decouple low.
- R9: If cfg_busy is high in a streaming cycle, the block leaves streaming at once into the error state of R8, and no further word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all activity |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse requesting a load |
| word_count | input | CW | Number of words in the image, 1..DEPTH |
| crc_expected | input | 32 | CRC the image must produce |
| module_id | input | ID_W | Identifier of the module in the image |
| err_clear | input | 1 | Clears the sticky error |
| fifo_level | input | CW | Words currently held in the source FIFO |
| fifo_data | input | DW | Head word of the FIFO (show-ahead) |
| fifo_pop | output | 1 | Consumes the FIFO head |
| cfg_en_n | output | 1 | Port enable, active low |
| cfg_rdwr_n | output | 1 | Port read/write select, low for write |
| cfg_data | output | DW | Port data bus |
| cfg_busy | input | 1 | Port busy flag |
| decouple | output | 1 | Isolates the region under reconfiguration |
| done | output | 1 | Last load passed its CRC |
| error | output | 1 | Sticky load failure |
| loaded_id | output | ID_W | Identifier of the module last loaded cleanly |

## Verification
The assertions take for granted that word_count never exceeds the FIFO depth. They also take for granted that the FIFO reports its level truthfully and holds valid head data whenever the level is non-zero, so that popping on an empty FIFO can only mean the loader failed to wait. The bench keeps to this: it draws counts from 1 to DEPTH and empties its FIFO model before each load. It raises cfg_busy only inside a directed case, in the middle of a stream, so the abort path is reached without making the random loads fail.

// File: rtl/pbit_loader.sv
module pbit_loader #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int ID_W  = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CW-1:0]   word_count,
  input  logic [31:0]     crc_expected,
  input  logic [ID_W-1:0] module_id,
  input  logic            err_clear,
  input  logic [CW-1:0]   fifo_level,
  input  logic [DW-1:0]   fifo_data,
  output logic            fifo_pop,
  output logic            cfg_en_n,
  output logic            cfg_rdwr_n,
  output logic [DW-1:0]   cfg_data,
  input  logic            cfg_busy,
  output logic            decouple,
  output logic            done,
  output logic            error,
  output logic [ID_W-1:0] loaded_id
);

  localparam logic [31:0] POLY = 32'h04C1_1DB7;

  typedef enum logic [2:0] {S_IDLE, S_PRIME, S_ARM, S_STREAM, S_CHECK, S_ERROR} st_t;

  st_t             st;
  logic [CW-1:0]   total, left;
  logic [31:0]     crc, crc_exp;
  logic [ID_W-1:0] id_q;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [DW-1:0] d);
    logic [31:0] r;
    r = c;
    for (int i = DW - 1; i >= 0; i--)
      r = {r[30:0], 1'b0} ^ ((r[31] ^ d[i]) ? POLY : 32'h0);
    return r;
  endfunction

  wire streaming = (st == S_STREAM);
  wire accept    = start && (word_count != '0) && (st == S_IDLE);

  assign fifo_pop   = streaming;
  assign cfg_en_n   = !streaming;
  assign cfg_data   = streaming ? fifo_data : '0;
  assign cfg_rdwr_n = (st == S_IDLE);
  assign decouple   = (st == S_ARM) || streaming || (st == S_CHECK) || (st == S_ERROR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      total     <= '0;
      left      <= '0;
      crc       <= '1;
      crc_exp   <= '0;
      id_q      <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
      loaded_id <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          total   <= word_count;
          left    <= word_count;
          crc     <= '1;
          crc_exp <= crc_expected;
          id_q    <= module_id;
          done    <= 1'b0;
          st      <= S_PRIME;
        end
        S_PRIME: if (fifo_level >= total) st <= S_ARM;
        S_ARM:   st <= S_STREAM;
        S_STREAM: begin
          crc  <= crc_step(crc, fifo_data);
          left <= left - CW'(1);
          if (cfg_busy) begin
            error     <= 1'b1;
            loaded_id <= '0;
            st        <= S_ERROR;
          end else if (left == CW'(1)) begin
            st <= S_CHECK;
          end
        end
        S_CHECK: if (crc == crc_exp) begin
          done      <= 1'b1;
          loaded_id <= id_q;
          st        <= S_IDLE;
        end else begin
          error     <= 1'b1;
          loaded_id <= '0;
          st        <= S_ERROR;
        end
        S_ERROR: if (err_clear) begin
          error <= 1'b0;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pbit_loader_chk.sv
module pbit_loader_chk #(
  parameter int DEPTH = 64
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cfg_en_n,
  input logic                         cfg_rdwr_n,
  input logic                         cfg_busy,
  input logic                         decouple,
  input logic                         fifo_pop,
  input logic [$clog2(DEPTH+1)-1:0]   fifo_level,
  input logic                         done,
  input logic                         error,
  input logic                         err_clear
);

  AST_WRITE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en_n |-> !cfg_rdwr_n); // R2

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> fifo_level != '0); // R4

  AST_EN_UNDER_DECOUPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en_n |-> decouple); // R5

  AST_DECOUPLE_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_en_n) |-> $past(decouple)); // R5

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !decouple && !error); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    error && !err_clear |=> error && decouple); // R8

  AST_BUSY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en_n && cfg_busy |=> cfg_en_n && error); // R9

endmodule

bind pbit_loader pbit_loader_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en_n(cfg_en_n), .cfg_rdwr_n(cfg_rdwr_n),
  .cfg_busy(cfg_busy), .decouple(decouple), .fifo_pop(fifo_pop),
  .fifo_level(fifo_level), .done(done), .error(error), .err_clear(err_clear)
);

// File: tb/sim_pbit_loader.sv
module sim_pbit_loader;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32, DEPTH = 64, ID_W = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, start = 0, err_clear = 0, cfg_busy = 0;
  logic [CW-1:0] word_count = '0, fifo_level;
  logic [31:0] crc_expected = '0;
  logic [ID_W-1:0] module_id = '0, loaded_id;
  logic [DW-1:0] fifo_data, cfg_data;
  logic fifo_pop, cfg_en_n, cfg_rdwr_n, decouple, done, error;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbit_loader #(.DW(DW), .DEPTH(DEPTH), .ID_W(ID_W)) u0 (.*);

  logic [DW-1:0] mem [0:255];
  int wr_ptr = 0, rd_ptr = 0;
  assign fifo_data  = mem[rd_ptr[7:0]];
  assign fifo_level = CW'(wr_ptr - rd_ptr);
  always @(posedge clk) if (fifo_pop) rd_ptr <= rd_ptr + 1;

  int n_chk = 0, n_fail = 0;
  int rx_n, load_base, load_cnt;
  logic [DW-1:0] rx [0:255];
  bit gap_bad, rdwr_bad, dec_bad, lead_bad, early_bad;
  logic prev_dec = 0, prev_en_n = 1;

  always @(negedge clk) begin
    if (!cfg_en_n) begin
      rx[rx_n[7:0]] = cfg_data;
      rx_n++;
      if (cfg_rdwr_n) rdwr_bad = 1;
      if (!decouple) dec_bad = 1;
      if (rx_n == 1 && !prev_dec) lead_bad = 1;
      if (rx_n > 1 && prev_en_n) gap_bad = 1;
      if (wr_ptr - load_base < load_cnt) early_bad = 1;
    end
    prev_dec  = decouple;
    prev_en_n = cfg_en_n;
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [DW-1:0] w[64], input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++)
      for (int b = DW - 1; b >= 0; b--) begin
        logic fb = c[31] ^ w[k][b];
        c = c << 1;
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    return c;
  endfunction

  task automatic run_load(int count, bit bad, bit slow, int busy_at, bit mid_start, bit err_start);
    logic [DW-1:0] w[64];
    logic [31:0] c;
    logic [ID_W-1:0] id = ID_W'($urandom);
    logic last_dec = 0, f_done, f_err, f_dec;
    int pushed = 0, guard = 0;
    bit was_done = done;
    bit fail_exp = bad || (busy_at >= 0);
    @(negedge clk);
    wr_ptr = rd_ptr;
    rx_n = 0; gap_bad = 0; rdwr_bad = 0; dec_bad = 0; lead_bad = 0; early_bad = 0;
    load_base = wr_ptr; load_cnt = count;
    for (int k = 0; k < count; k++) w[k] = DW'($urandom);
    c = ref_crc(w, count);
    if (!slow) begin
      for (int k = 0; k < count; k++) begin mem[wr_ptr[7:0]] = w[k]; wr_ptr++; end
      pushed = count;
    end
    start = 1; word_count = CW'(count); crc_expected = bad ? (c ^ 32'h100) : c; module_id = id;
    @(negedge clk);
    start = 0;
    if (was_done) chk(done == 0, "R7", "done cleared by new start", done, 0);
    chk(cfg_rdwr_n == 0, "R2", "write select low after start", cfg_rdwr_n, 0);
    while (pushed < count) begin
      repeat (1 + $urandom % 3) @(negedge clk);
      mem[wr_ptr[7:0]] = w[pushed]; wr_ptr++; pushed++;
    end
    if (busy_at >= 0 || mid_start) begin
      while (cfg_en_n) @(negedge clk);
      if (mid_start) begin
        start = 1; word_count = CW'(3); module_id = ~id;
        @(negedge clk); start = 0;
      end
      if (busy_at >= 0) begin
        repeat (busy_at) @(negedge clk);
        cfg_busy = 1; @(negedge clk); cfg_busy = 0;
      end
    end
    forever begin
      if (done || error || guard > 400) break;
      last_dec = decouple;
      @(negedge clk); guard++;
    end
    f_done = done; f_err = error; f_dec = decouple;
    @(negedge clk);
    chk(!early_bad, "R4", "word presented before FIFO filled", early_bad, 0);
    chk(!gap_bad, "R4", "gap between words", gap_bad, 0);
    chk(!rdwr_bad, "R2", "read select during write", rdwr_bad, 0);
    chk(!dec_bad && !lead_bad, "R5", "decouple around stream", {dec_bad, lead_bad}, 0);
    if (busy_at >= 0) begin
      chk(rx_n == busy_at + 1, "R9", "words before busy abort", rx_n, busy_at + 1);
      chk(f_err && !f_done, "R9", "busy abort flags", {f_done, f_err}, 1);
    end else begin
      chk(rx_n == count, "R4", "word count", rx_n, count);
      for (int k = 0; k < count; k++)
        if (rx[k] != w[k]) chk(0, "R4", $sformatf("word %0d", k), rx[k], w[k]);
    end
    if (!fail_exp) begin
      chk(f_done && !f_err, "R6", "CRC match gives done", {f_done, f_err}, 2);
      chk(!f_dec && last_dec, "R7", "decouple release timing", {last_dec, f_dec}, 2);
      chk(loaded_id == id, "R7", "loaded id", loaded_id, id);
      repeat (3) @(negedge clk);
      chk(done == 1, "R7", "done held in idle", done, 1);
    end else begin
      chk(f_err && !f_done && f_dec, "R8", "error flags", {f_done, f_err, f_dec}, 3);
      chk(loaded_id == 0, "R8", "loaded id cleared", loaded_id, 0);
      repeat (3) @(negedge clk);
      chk(error && decouple, "R8", "error sticky", {error, decouple}, 3);
      if (err_start) begin
        start = 1; word_count = CW'(4); @(negedge clk); start = 0;
        repeat (4) @(negedge clk);
        chk(error && decouple && cfg_en_n, "R3", "start ignored in error", {error, decouple, cfg_en_n}, 7);
      end
      err_clear = 1; @(negedge clk); err_clear = 0;
      chk(!error && !decouple && cfg_rdwr_n, "R8", "error cleared", {error, decouple}, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20131209));
    repeat (3) @(negedge clk);
    chk(cfg_en_n && cfg_rdwr_n && !fifo_pop, "R1", "port idle in reset", {cfg_en_n, cfg_rdwr_n, fifo_pop}, 6);
    chk(!decouple && !done && !error && loaded_id == 0, "R1", "flags in reset",
        {decouple, done, error, loaded_id}, 0);
    rst_n = 1;
    @(negedge clk);
    rx_n = 0;
    start = 1; word_count = '0; @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    chk(cfg_rdwr_n && !decouple && rx_n == 0, "R3", "zero count ignored", {cfg_rdwr_n, decouple}, 2);
    run_load(1, 0, 0, -1, 0, 0);
    run_load(DEPTH, 0, 0, -1, 0, 0);
    run_load(10, 0, 1, -1, 0, 0);
    run_load(12, 0, 0, -1, 1, 0);
    run_load(7, 1, 0, -1, 0, 1);
    run_load(8, 0, 0, 2, 0, 0);
    for (int i = 0; i < 14; i++)
      run_load(1 + $urandom % DEPTH, ($urandom % 4) == 0, ($urandom % 3) == 0, -1, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule